// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Overflow-Safe Signed Compare

This block is a combinational integer ALU for a configurable word width. It is built from a chain of identical one-bit slices. The topmost slice is a variant that carries extra comparison logic. Every slice forms the AND, the OR and the full-adder sum of its `opA` bit with either the `opB` bit or its complement. A two-bit select chooses which of these appears at the slice output. Carries ripple from slice 0 upward.

Subtraction is addition of the inverted operand with a carry-in of one. The caller requests it by driving `bInvert` and `carryIn` high together. The same two controls turn the less-than operation into a signed comparison.

The less-than bit is not the raw sign of the difference. The top slice corrects the sign with the signed-overflow term, so the answer stays right when the difference does not fit in the word. This bit is routed back into bit 0 of the result, and all higher result bits read zero for that operation. The carry-out, overflow and zero flags accompany every result.

Top module: `slice_alu`

## Requirements
- R1: With `opSel` = 2'b00, `result` equals `opA` AND the effective operand, where the effective operand is `opB` when `bInvert` = 0 and the bitwise complement of `opB` when `bInvert` = 1.
- R2: With `opSel` = 2'b01, `result` equals `opA` OR the effective operand.
- R3: With `opSel` = 2'b10 and `bInvert` = 0, {`carryOut`, `result`} equals the unsigned sum `opA` + `opB` + `carryIn`, carried out of the top bit.
- R4: With `opSel` = 2'b10, `bInvert` = 1 and `carryIn` = 1, `result` equals `opA` − `opB` modulo 2^WIDTH. `carryOut` is 1 exactly when `opA` ≥ `opB` as unsigned values.
- R5: For every `opSel`, `overflow` is 1 exactly when the two's-complement sum `opA` + effective operand + `carryIn` falls outside the signed range of WIDTH bits.
- R6: With `opSel` = 2'b11, bits WIDTH−1..1 of `result` are 0. Bit 0 is 1 exactly when the exact signed value of `opA` + effective operand + `carryIn` is negative. With `bInvert` = 1 and `carryIn` = 1 this is the signed comparison `opA` < `opB`, and it holds when the subtraction overflows.
- R7: At WIDTH = 4, comparing `opA` = 4'b1001 (−7) with `opB` = 4'b0110 (6) using `opSel` = 2'b11, `bInvert` = 1 and `carryIn` = 1 gives `result` = 4'b0001, although the wrapped difference 4'b0011 is positive.
- R8: `zero` is 1 exactly when every bit of `result` is 0, for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, optionally complemented |
| bInvert | input | 1 | Complement `opB` before it enters the slices |
| carryIn | input | 1 | Carry into slice 0 (1 for subtract and compare) |
| opSel | input | 2 | 00 AND, 01 OR, 10 add/subtract, 11 less-than |
| result | output | WIDTH | Selected result word |
| carryOut | output | 1 | Carry out of the top slice |
| overflow | output | 1 | Signed overflow of the adder path |
| zero | output | 1 | All result bits are zero |

## Verification
The bench builds the block twice, at the default width of 32 and at a width of 4. The 4-bit copy is small enough to be driven through every pair of operands under every select, invert and carry-in combination. That covers every overflow and compare corner exhaustively, including the −7 versus 6 case. The 32-bit copy receives directed vectors at the signed extremes 0x7FFFFFFF and 0x80000000, together with random vectors, so the long carry chain and the top-slice correction are exercised at full width.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } opSel_e;

  typedef struct packed {
    logic pickAnd;
    logic pickOr;
    logic pickSum;
    logic pickLess;
  } sliceCtrl_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0] opSel,
  output sliceCtrl_t ctrl
);
  always_comb begin
    ctrl = '0;
    case (opSel_e'(opSel))
      OP_AND:  ctrl.pickAnd  = 1'b1;
      OP_OR:   ctrl.pickOr   = 1'b1;
      OP_SUM:  ctrl.pickSum  = 1'b1;
      default: ctrl.pickLess = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       bInvert,
  input  logic       cin,
  input  logic       less,
  input  sliceCtrl_t ctrl,
  output logic       res,
  output logic       cout
);
  logic bEff;
  logic sum;

  always_comb begin
    bEff = b ^ bInvert;
    sum  = a ^ bEff ^ cin;
    cout = (a & bEff) | (a & cin) | (bEff & cin);
    res  = (ctrl.pickAnd  & (a & bEff))
         | (ctrl.pickOr   & (a | bEff))
         | (ctrl.pickSum  & sum)
         | (ctrl.pickLess & less);
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       bInvert,
  input  logic       cin,
  input  logic       less,
  input  sliceCtrl_t ctrl,
  output logic       res,
  output logic       cout,
  output logic       set,
  output logic       ovf
);
  logic rawSign;

  alu_slice u_core (
    .a(a), .b(b), .bInvert(bInvert), .cin(cin), .less(less),
    .ctrl(ctrl), .res(res), .cout(cout)
  );

  // Sign of the wrapped sum, corrected by overflow into the true sign.
  always_comb begin
    rawSign = a ^ (b ^ bInvert) ^ cin;
    ovf     = cin ^ cout;
    set     = rawSign ^ ovf;
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             bInvert,
  input  logic             carryIn,
  input  sliceCtrl_t       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] lessIn;
  logic             setMsb;

  assign carry[0] = carryIn;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      if (i == 0) begin : g_lsb_less
        assign lessIn[i] = setMsb;
      end else begin : g_tied_less
        assign lessIn[i] = 1'b0;
      end

      if (i == TOP) begin : g_top
        alu_msb_slice u_msb (
          .a(opA[i]), .b(opB[i]), .bInvert(bInvert), .cin(carry[i]),
          .less(lessIn[i]), .ctrl(ctrl), .res(result[i]),
          .cout(carry[i+1]), .set(setMsb), .ovf(overflow)
        );
      end else begin : g_body
        alu_slice u_bit (
          .a(opA[i]), .b(opB[i]), .bInvert(bInvert), .cin(carry[i]),
          .less(lessIn[i]), .ctrl(ctrl), .res(result[i]),
          .cout(carry[i+1])
        );
      end
    end
  endgenerate

  assign carryOut = carry[WIDTH];
  assign zero     = ~|result;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             bInvert,
  input  logic             carryIn,
  input  logic [1:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero
);
  sliceCtrl_t ctrl;

  alu_ctrl u_ctrl (
    .opSel(opSel),
    .ctrl(ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA(opA), .opB(opB), .bInvert(bInvert), .carryIn(carryIn),
    .ctrl(ctrl), .result(result), .carryOut(carryOut),
    .overflow(overflow), .zero(zero)
  );
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             bInvert,
  input logic             carryIn,
  input logic [1:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             overflow,
  input logic             zero
);
  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   wideSum;
  logic             sameSign;

  always_comb begin
    bEff     = bInvert ? ~opB : opB;
    wideSum  = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, carryIn};
    sameSign = (opA[WIDTH-1] == bEff[WIDTH-1]);

    if (opSel == 2'b00)
      a_r1_and_word: assert (result == (opA & bEff))
        else $error("R1 and mismatch");
    if (opSel == 2'b01)
      a_r2_or_word: assert (result == (opA | bEff))
        else $error("R2 or mismatch");
    if (opSel == 2'b10)
      a_r3_sum_carry: assert ({carryOut, result} == wideSum)
        else $error("R3 sum mismatch");
    a_r5_overflow: assert (overflow == (sameSign && (wideSum[WIDTH-1] != opA[WIDTH-1])))
      else $error("R5 overflow mismatch");
    if (opSel == 2'b11)
      a_r6_upper_clear: assert (result[WIDTH-1:1] == '0)
        else $error("R6 upper bits set");
    if (opSel == 2'b11 && bInvert && carryIn)
      a_r6_signed_less: assert (result[0] == ($signed(opA) < $signed(opB)))
        else $error("R6 compare mismatch");
    if (zero)
      a_r8_zero_flag: assert (result == '0)
        else $error("R8 zero with nonzero result");
  end
endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opA(opA), .opB(opB), .bInvert(bInvert), .carryIn(carryIn),
  .opSel(opSel), .result(result), .carryOut(carryOut),
  .overflow(overflow), .zero(zero)
);

// File: tb/slice_alu_bench.sv
module slice_alu_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  logic [31:0] wA, wB, wRes;
  logic        wInv, wCin, wCo, wOvf, wZero;
  logic [1:0]  wOp;
  logic [3:0]  nA, nB, nRes;
  logic        nInv, nCin, nCo, nOvf, nZero;
  logic [1:0]  nOp;

  slice_alu #(.WIDTH(32)) u_slice_alu (
    .opA(wA), .opB(wB), .bInvert(wInv), .carryIn(wCin), .opSel(wOp),
    .result(wRes), .carryOut(wCo), .overflow(wOvf), .zero(wZero)
  );

  slice_alu #(.WIDTH(4)) u_slice_alu_narrow (
    .opA(nA), .opB(nB), .bInvert(nInv), .carryIn(nCin), .opSel(nOp),
    .result(nRes), .carryOut(nCo), .overflow(nOvf), .zero(nZero)
  );

  function automatic longint sx(input longint unsigned v, input int w);
    return longint'(v << (64 - w)) >>> (64 - w);
  endfunction

  // Behavioural reference: wide integer arithmetic, no slices.
  task automatic model(input int w, input longint unsigned a, input longint unsigned b,
                       input bit bi, input bit ci, input int op,
                       output longint unsigned res, output bit co,
                       output bit ovf, output bit zf);
    longint unsigned mask, be, full;
    longint exact, hi, lo;
    mask  = (64'd1 << w) - 1;
    be    = bi ? (~b & mask) : (b & mask);
    full  = (a & mask) + be + longint'(ci);
    co    = full[w];
    exact = sx(a & mask, w) + sx(be, w) + longint'(ci);
    hi    = (64'sd1 <<< (w - 1)) - 1;
    lo    = -(64'sd1 <<< (w - 1));
    ovf   = (exact > hi) || (exact < lo);
    case (op)
      0: res = a & be & mask;
      1: res = (a | be) & mask;
      2: res = full & mask;
      default: res = (exact < 0) ? 64'd1 : 64'd0;
    endcase
    zf = (res == 0);
  endtask

  function automatic string opTag(input int op, input bit bi);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return bi ? "R4" : "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic compare(input string tag, input longint unsigned aRes, input bit aCo,
                         input bit aOvf, input bit aZ, input longint unsigned eRes,
                         input bit eCo, input bit eOvf, input bit eZ);
    nVec++;
    if (aRes != eRes || aCo != eCo) begin
      nBad++;
      $display("FAIL %s result/carry actual=%h/%0b expected=%h/%0b", tag, aRes, aCo, eRes, eCo);
    end
    if (aOvf != eOvf) begin
      nBad++;
      $display("FAIL R5 overflow actual=%0b expected=%0b", aOvf, eOvf);
    end
    if (aZ != eZ) begin
      nBad++;
      $display("FAIL R8 zero actual=%0b expected=%0b", aZ, eZ);
    end
  endtask

  task automatic runWide(input logic [31:0] a, input logic [31:0] b, input bit bi,
                         input bit ci, input int op, input string tag);
    longint unsigned eRes;
    bit eCo, eOvf, eZ;
    @(posedge clk);
    wA = a; wB = b; wInv = bi; wCin = ci; wOp = op[1:0];
    model(32, 64'(a), 64'(b), bi, ci, op, eRes, eCo, eOvf, eZ);
    @(negedge clk);
    compare(tag, 64'(wRes), wCo, wOvf, wZero, eRes, eCo, eOvf, eZ);
  endtask

  task automatic runNarrow(input logic [3:0] a, input logic [3:0] b, input bit bi,
                           input bit ci, input int op, input string tag);
    longint unsigned eRes;
    bit eCo, eOvf, eZ;
    @(posedge clk);
    nA = a; nB = b; nInv = bi; nCin = ci; nOp = op[1:0];
    model(4, 64'(a), 64'(b), bi, ci, op, eRes, eCo, eOvf, eZ);
    @(negedge clk);
    compare(tag, 64'(nRes), nCo, nOvf, nZero, eRes, eCo, eOvf, eZ);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    wA = '0; wB = '0; wInv = 1'b0; wCin = 1'b0; wOp = 2'b00;
    nA = '0; nB = '0; nInv = 1'b0; nCin = 1'b0; nOp = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: zero operands under reset give a zero result and raised flag
    compare("R8", 64'(wRes), wCo, wOvf, wZero, 64'd0, 1'b0, 1'b0, 1'b1);
    rstN = 1'b1;

    runWide(32'hF0F0_A5A5, 32'h0FF0_FFFF, 0, 0, 0, "R1");
    runWide(32'hF0F0_A5A5, 32'h0FF0_FFFF, 1, 0, 0, "R1");
    runWide(32'h1234_0000, 32'h0000_5678, 0, 0, 1, "R2");
    runWide(32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 2, "R3");
    runWide(32'hFFFF_FFFF, 32'h0000_0000, 0, 1, 2, "R3");
    runWide(32'h0000_0005, 32'h0000_0007, 1, 1, 2, "R4");
    runWide(32'h8000_0000, 32'h0000_0001, 1, 1, 2, "R4");
    runWide(32'h8000_0000, 32'h7FFF_FFFF, 1, 1, 3, "R6");
    runWide(32'h7FFF_FFFF, 32'h8000_0000, 1, 1, 3, "R6");
    runWide(32'h8000_0000, 32'h8000_0000, 1, 1, 3, "R6");
    runWide(32'h1234_5678, 32'h1234_5678, 1, 1, 2, "R8");
    runNarrow(4'b1001, 4'b0110, 1, 1, 3, "R7");

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int op = 0; op < 4; op++)
          for (int m = 0; m < 4; m++)
            runNarrow(a[3:0], b[3:0], m[1], m[0], op, opTag(op, m[1]));

    for (int k = 0; k < 2000; k++) begin
      int op;
      bit bi, ci;
      op = int'($urandom_range(0, 3));
      bi = 1'($urandom);
      ci = (op == 3) ? bi : 1'($urandom);
      runWide($urandom, $urandom, bi, ci, op, opTag(op, bi));
    end

    finishRun();
  end
endmodule